// File: doc/BRIEF.md
# Multi-Tap Programmable Clock Divider

This block turns one fast reference clock into four related clocks whose frequencies step down by octaves. Each tap is a square wave built from a counter clocked by the reference. All taps share one runtime post-divide factor, N+1, where N comes from a 3-bit input. A static ladder parameter picks between two ladders. The slow ladder is the default, and its fastest tap is half the reference. The fast ladder is one octave quicker, and its fastest tap is the reference itself, gated.

Running is controlled by an enable input and a force input. When force is high, the enable has no effect. An asynchronous clear drives every tap low at once, with no clock needed, and its own ignore input can neutralise it. A second, active-low clear resets only the divider stage. After any clear, and after each restart, every tap begins low and all taps stay phase-aligned.

A new divide value is taken only at the end of a period of the slowest tap, when all taps restart together. No tap ever shows a shortened pulse.

Top module: `octave_tap_divider`

## Requirements
- R1: `post_div` is an unsigned binary value N that gives a post-divide factor of N+1 (0 gives 1, 7 gives 8), and this factor multiplies the period of every tap.
- R2: With `LADDER = LADDER_PERF` (the default), tap k (`tap_o[k]`, where k=0 is the fastest) has a period of (N+1)·2^(k+1) reference cycles. That is 2, 4, 8 and 16 times (N+1).
- R3: With `LADDER = LADDER_POWER`, tap k has a period of (N+1)·2^k reference cycles. A tap whose total ratio is 1 outputs the reference clock ANDed with the running state.
- R4: When `kill` is high and `kill_ignore` is low, all taps go low immediately, with no clock edge.
- R5: When `kill_ignore` is high, `kill` has no effect and the taps keep running.
- R6: `div_rst_n` low clears the divider and holds all taps low. At the first reference edge after any clear is released with the block enabled, every tap starts at the beginning of its low phase.
- R7: When `run_en` and `run_force` are both low, all taps are low from the next reference edge. When running resumes, all taps restart phase-aligned from their low phase.
- R8: When `run_force` is high, `run_en` is ignored and the taps run.
- R9: A change of `post_div` takes effect only when the slowest tap completes its period, at its falling edge, where all taps restart together. It also takes effect on a restart from idle.
- R10: A tap of total ratio R is low for the first ceil(R/2) reference cycles of each period and high for the last floor(R/2). For odd R it is therefore high for floor(R/2) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| run_en | input | 1 | Run enable, active high |
| run_force | input | 1 | When high, the taps run whatever `run_en` is |
| kill | input | 1 | Asynchronous clear of all taps, active high |
| kill_ignore | input | 1 | When high, `kill` has no effect |
| div_rst_n | input | 1 | Active-low clear of the divider stage |
| post_div | input | 3 | Post-divide value N, factor N+1 |
| tap_o | output | 4 | Divided taps, bit 0 fastest |

## Verification
The bench builds two instances with the default widths, 3 divide bits and 4 taps, and drives both from the same stimulus. One uses the slow ladder and the other the fast ladder. Only the fast ladder reaches a total ratio of 1, where the reference passes through, and odd total ratios, where the duty split is uneven. The slow ladder reaches the longest period of 128 cycles, where divide changes are deferred the longest. A behavioural model computes each tap from a cycle count modulo its ratio and is compared against both instances on every clock.

// File: rtl/octave_div_pkg.sv
`timescale 1ns/1ps
package octave_div_pkg;

  typedef enum logic {
    LADDER_PERF  = 1'b0,
    LADDER_POWER = 1'b1
  } ladder_e;

  // total ratio of tap k for post-divide value n
  function automatic int unsigned tap_ratio(ladder_e lad, int k, int unsigned n);
    int unsigned sh;
    sh = int'(k) + ((lad == LADDER_PERF) ? 1 : 0);
    return (n + 1) << sh;
  endfunction

  // first count value of the high phase: ceil(r/2)
  function automatic int unsigned high_start(int unsigned r);
    return (r + 1) >> 1;
  endfunction

endpackage

// File: rtl/odt_tap_ctrl.sv
`timescale 1ns/1ps
module odt_tap_ctrl #(
  parameter int DIV_W = 3
) (
  input  logic             clk_ref,
  input  logic             run_en,
  input  logic             run_force,
  input  logic             kill,
  input  logic             kill_ignore,
  input  logic             div_rst_n,
  input  logic [DIV_W-1:0] post_div,
  input  logic             period_end,
  output logic             clear_any,
  output logic             gate,
  output logic             active,
  output logic             restart,
  output logic [DIV_W-1:0] n_cur
);

  assign clear_any = (kill & ~kill_ignore) | ~div_rst_n;
  assign gate      = run_en | run_force;
  // every counter returns to zero: idle, first active edge or slowest wrap
  assign restart   = ~gate | ~active | period_end;

  always_ff @(posedge clk_ref or posedge clear_any) begin
    if (clear_any) begin
      active <= 1'b0;
      n_cur  <= '0;
    end else begin
      active <= gate;
      if (restart) n_cur <= post_div;
    end
  end

endmodule

// File: rtl/odt_tap_counter.sv
`timescale 1ns/1ps
module odt_tap_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_ref,
  input  logic             clear_any,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] ratio,
  output logic             tap_q,
  output logic             at_last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] hi_mark;

  assign hi_mark = CNT_W'(octave_div_pkg::high_start(32'(ratio)));
  assign at_last = (cnt_q == ratio - CNT_W'(1));

  always_comb begin
    if (restart || at_last) cnt_nxt = '0;
    else                    cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_ref or posedge clear_any) begin
    if (clear_any) begin
      cnt_q <= '0;
      tap_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      tap_q <= run && (cnt_nxt >= hi_mark);
    end
  end

endmodule

// File: rtl/octave_tap_divider.sv
`timescale 1ns/1ps
module octave_tap_divider #(
  parameter int                      DIV_W  = 3,
  parameter int                      NTAPS  = 4,
  parameter octave_div_pkg::ladder_e LADDER = octave_div_pkg::LADDER_PERF
) (
  input  logic             clk_ref,
  input  logic             run_en,
  input  logic             run_force,
  input  logic             kill,
  input  logic             kill_ignore,
  input  logic             div_rst_n,
  input  logic [DIV_W-1:0] post_div,
  output logic [NTAPS-1:0] tap_o
);

  localparam int CNT_W = DIV_W + NTAPS + 1;

  logic             clear_any;
  logic             gate;
  logic             active;
  logic             restart;
  logic             period_end;
  logic [DIV_W-1:0] n_cur;
  logic [NTAPS-1:0] tap_q;
  logic [NTAPS-1:0] at_last;
  logic [CNT_W-1:0] ratio [NTAPS];

  // all counters sit on their last count only at the slowest tap's wrap
  assign period_end = active & (&at_last);

  odt_tap_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk_ref    (clk_ref),
    .run_en     (run_en),
    .run_force  (run_force),
    .kill       (kill),
    .kill_ignore(kill_ignore),
    .div_rst_n  (div_rst_n),
    .post_div   (post_div),
    .period_end (period_end),
    .clear_any  (clear_any),
    .gate       (gate),
    .active     (active),
    .restart    (restart),
    .n_cur      (n_cur)
  );

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    assign ratio[k] = CNT_W'(octave_div_pkg::tap_ratio(LADDER, k, 32'(n_cur)));

    odt_tap_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_ref  (clk_ref),
      .clear_any(clear_any),
      .restart  (restart),
      .run      (gate),
      .ratio    (ratio[k]),
      .tap_q    (tap_q[k]),
      .at_last  (at_last[k])
    );

    // a total ratio of one passes the reference through while running
    assign tap_o[k] = (ratio[k] == CNT_W'(1)) ? (clk_ref & active) : tap_q[k];
  end

endmodule

// File: rtl/odt_checker.sv
`timescale 1ns/1ps
module odt_checker #(
  parameter int DIV_W = 3,
  parameter int NTAPS = 4
) (
  input logic             clk_ref,
  input logic             clear_any,
  input logic             gate,
  input logic             active,
  input logic             run_force,
  input logic             kill,
  input logic             kill_ignore,
  input logic             period_end,
  input logic [DIV_W-1:0] n_cur,
  input logic [NTAPS-1:0] tap_q
);

  // R7: idle request drives every tap low at the next edge
  a_r7_idle_low: assert property (@(posedge clk_ref) disable iff (clear_any)
    !gate |=> (tap_q == '0));

  // R6: the first active cycle begins in the low phase on all taps
  a_r6_start_low: assert property (@(posedge clk_ref) disable iff (clear_any)
    $rose(active) |-> (tap_q == '0));

  // R9: divide value held through a running period
  a_r9_div_stable: assert property (@(posedge clk_ref) disable iff (clear_any)
    (active && gate && !period_end) |=> $stable(n_cur));

  // R2: slowest tap rises only while every faster tap is at a low phase start
  a_r2_ladder_nested: assert property (@(posedge clk_ref) disable iff (clear_any)
    $rose(tap_q[NTAPS-1]) |-> (tap_q[NTAPS-2:0] == '0));

  // R8: force keeps the divider running
  a_r8_force_runs: assert property (@(posedge clk_ref) disable iff (clear_any)
    run_force |=> active);

  // R5: an ignored kill does not stop the divider
  a_r5_kill_masked: assert property (@(posedge clk_ref) disable iff (clear_any)
    (kill && kill_ignore && gate) |=> active);

endmodule

bind octave_tap_divider odt_checker #(.DIV_W(DIV_W), .NTAPS(NTAPS)) u_chk (
  .clk_ref    (clk_ref),
  .clear_any  (clear_any),
  .gate       (gate),
  .active     (active),
  .run_force  (run_force),
  .kill       (kill),
  .kill_ignore(kill_ignore),
  .period_end (period_end),
  .n_cur      (n_cur),
  .tap_q      (tap_q)
);

// File: tb/tb_octave_tap_divider.sv
`timescale 1ns/1ps
module tb_octave_tap_divider;

  logic       clk = 1'b0;
  logic       run_en, run_force, kill, kill_ignore, div_rst_n;
  logic [2:0] post_div;
  logic [3:0] tap_pf, tap_pw;

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R6";
  bit    mon_on = 1'b0;
  bit    done   = 1'b0;

  // model state, index 0 = slow ladder, 1 = fast ladder
  int m_act [2];
  int m_t   [2];
  int m_n   [2];

  always #2 clk = ~clk;

  octave_tap_divider dut (
    .clk_ref(clk), .run_en(run_en), .run_force(run_force), .kill(kill),
    .kill_ignore(kill_ignore), .div_rst_n(div_rst_n), .post_div(post_div),
    .tap_o(tap_pf));

  octave_tap_divider #(.LADDER(octave_div_pkg::LADDER_POWER)) dut_pw (
    .clk_ref(clk), .run_en(run_en), .run_force(run_force), .kill(kill),
    .kill_ignore(kill_ignore), .div_rst_n(div_rst_n), .post_div(post_div),
    .tap_o(tap_pw));

  function automatic int mratio(int md, int k, int n);
    int r = n + 1;
    int steps = k + ((md == 0) ? 1 : 0);
    for (int i = 0; i < steps; i++) r = r * 2;
    return r;
  endfunction

  // expected taps, sampled while the reference is high
  function automatic logic [3:0] mexp(int md);
    logic [3:0] e = '0;
    for (int k = 0; k < 4; k++) begin
      int r = mratio(md, k, m_n[md]);
      if (m_act[md] == 0) e[k] = 1'b0;
      else if (r == 1)    e[k] = 1'b1;
      else                e[k] = ((m_t[md] % r) >= (r - r / 2));
    end
    return e;
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: got %b expected %b", req, what, $time, act, exp);
    end
  endtask

  task automatic step_model(int md);
    bit clr = (kill && !kill_ignore) || !div_rst_n;
    bit g   = run_en || run_force;
    if (clr) begin
      m_act[md] = 0; m_t[md] = 0; m_n[md] = 0;
    end else if (!g) begin
      m_act[md] = 0; m_t[md] = 0; m_n[md] = int'(post_div);
    end else if (m_act[md] == 0) begin
      m_act[md] = 1; m_t[md] = 0; m_n[md] = int'(post_div);
    end else begin
      m_t[md]++;
      if (m_t[md] == mratio(md, 3, m_n[md])) begin
        m_t[md] = 0; m_n[md] = int'(post_div);
      end
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      step_model(0);
      step_model(1);
      check(tag, tap_pf, mexp(0), "slow ladder");
      check(tag, tap_pw, mexp(1), "fast ladder");
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    div_rst_n = 1'b0; run_en = 1'b0; run_force = 1'b0;
    kill = 1'b0; kill_ignore = 1'b0; post_div = 3'd0;
    for (int i = 0; i < 2; i++) begin m_act[i] = 0; m_t[i] = 0; m_n[i] = 0; end
    mon_on = 1'b1;
    tag = "R6";
    cycles(3);
    check("R6", tap_pf, 4'b0000, "reset state slow");
    check("R6", tap_pw, 4'b0000, "reset state fast");

    // release and run at N=0: taps begin low (fast tap0 is pass-through)
    tag = "R2 R3";
    div_rst_n = 1'b1; run_en = 1'b1;
    @(posedge clk); #1;
    check("R6", tap_pf, 4'b0000, "first edge after release slow");
    check("R3", tap_pw, 4'b0001, "first edge after release fast");
    cycles(40);

    // change mid-period: deferred to the slowest wrap
    @(negedge clk); tag = "R9"; post_div = 3'd2;
    cycles(120);

    @(negedge clk); tag = "R1"; post_div = 3'd7;
    cycles(300);

    // odd factor 5: fast tap0 ratio 5 high 2 of 5
    @(negedge clk); tag = "R10"; post_div = 3'd4;
    cycles(200);

    // idle
    @(negedge clk); tag = "R7"; run_en = 1'b0;
    cycles(12);
    check("R7", tap_pf, 4'b0000, "idle slow");
    check("R7", tap_pw, 4'b0000, "idle fast");
    @(negedge clk); post_div = 3'd1; run_en = 1'b1;
    cycles(40);

    // force overrides a low enable
    @(negedge clk); tag = "R8"; run_en = 1'b0; run_force = 1'b1;
    cycles(60);

    // asynchronous clear, checked between edges
    @(negedge clk); tag = "R4"; kill = 1'b1;
    #1;
    check("R4", tap_pf, 4'b0000, "immediate kill slow");
    check("R4", tap_pw, 4'b0000, "immediate kill fast");
    cycles(3);
    @(negedge clk); tag = "R6"; kill = 1'b0; run_force = 1'b0; run_en = 1'b1;
    cycles(40);

    // ignored clear
    @(negedge clk); tag = "R5"; kill_ignore = 1'b1; kill = 1'b1;
    cycles(60);
    @(negedge clk); kill = 1'b0; kill_ignore = 1'b0;

    // divider clear mid-run
    @(negedge clk); tag = "R6"; div_rst_n = 1'b0;
    cycles(4);
    check("R6", tap_pf, 4'b0000, "divider clear slow");
    check("R6", tap_pw, 4'b0000, "divider clear fast");
    @(negedge clk); div_rst_n = 1'b1; post_div = 3'd7;
    cycles(20);

    // several changes inside one long period: only the last one counts
    tag = "R9";
    @(negedge clk); post_div = 3'd3;
    cycles(10);
    @(negedge clk); post_div = 3'd5;
    cycles(10);
    @(negedge clk); post_div = 3'd0;
    cycles(250);

    mon_on = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule